// File: doc/BRIEF.md
# Transmit Packet Framer

This block turns the bytes waiting in a transmit FIFO into a serial bit stream, one bit per baud tick, most significant bit first. With framing on, it wraps the FIFO bytes in a fixed order of fields. First comes an alternating preamble of programmable length. Then come a sync word of one to four bytes and an optional two-byte header, then the payload taken from the FIFO, and finally a 16-bit CRC over the header and payload. With framing off, the FIFO bytes go out exactly as stored. The host must then place any preamble and sync pattern in the FIFO itself.

A single-cycle start pulse captures the whole configuration, the FIFO fill level (which becomes the payload length) and a 4-bit completion-state code. Configuration changes made while a packet is in flight have no effect. When the last bit has had its full bit period, the block pulses a packet-sent event and presents the completion code on `done_state`, so that surrounding control can return on its own to the state the host chose.

The payload side is a valid/ready pop interface with strict rules. The framer raises `fifo_ready` for exactly one cycle, in the tick cycle that begins each payload byte, and takes `fifo_data` in that cycle. It never waits. If `fifo_valid` is low at that moment, the packet is aborted and an underflow event is pulsed. The FIFO therefore sees back-pressure only in the sense that no pop occurs outside those cycles. Modulation is outside this block.

Top module: `pkt_tx_framer`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `tx_data`, `busy`, `fifo_ready`, `pkt_sent` and `underflow` are 0 and `done_state` is 0.
- R2: A `start` pulse while idle captures the configuration, `fifo_level` and `start_next`, and sets `busy` at the next edge. A `start` pulse while busy, and any configuration change while busy, do not alter the bits sent or the reported completion code.
- R3: Exactly one bit is sent per `bit_tick`, MSB first. `tx_data` changes only at an edge where `bit_tick` is high. The first bit appears at the first tick after the start cycle. A completed packet of N bits uses N+1 ticks.
- R4: With `cfg_frame_en`=1, the fields are sent in this order. The preamble is `cfg_pre_bytes` bytes of 0xAA, and a value of 0 acts as 1. The sync word is `cfg_sync_bytes`+1 bytes taken from `cfg_sync_word`, starting at bits [31:24] and moving downward. When `cfg_hdr_en`=1, the header follows as `cfg_hdr_word[15:8]` then `[7:0]`. Then come the payload bytes, and last the CRC, high byte first.
- R5: The CRC uses polynomial 0x1021 with initial value 0xFFFF, MSB-first and unreflected, with no final XOR. It covers the header and payload bytes only. The nine ASCII bytes "123456789" give 0x29B1.
- R6: With `cfg_frame_en`=0, only the payload bytes are sent, unchanged, with no added field.
- R7: The payload is `fifo_level` bytes as captured at start. `fifo_ready` is high only in a tick cycle that begins a payload byte, and exactly `fifo_level` bytes are popped for a completed packet.
- R8: At the tick after the last bit's tick, `pkt_sent` pulses for one cycle, `busy` falls and `done_state` takes the captured `start_next`. With an empty unframed packet this happens at the first tick.
- R9: If `fifo_valid` is low when a payload byte is due, `underflow` pulses for one cycle and `busy` falls. `pkt_sent` stays low and `done_state` keeps its value.
- R10: `tx_data` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_next | input | ST_W (4) | Completion-state code reported after the packet |
| cfg_frame_en | input | 1 | 1 adds preamble, sync, header and CRC; 0 sends the FIFO bytes only |
| cfg_pre_bytes | input | PRE_W (8) | Preamble length in bytes (0 acts as 1) |
| cfg_sync_bytes | input | log2(SYNC_BYTES) (2) | Sync length minus one, in bytes |
| cfg_sync_word | input | 8*SYNC_BYTES (32) | Sync pattern, sent from the top byte down |
| cfg_hdr_en | input | 1 | Adds the header field |
| cfg_hdr_word | input | 8*HDR_BYTES (16) | Header bytes, top byte first |
| fifo_level | input | LVL_W (8) | FIFO fill level, captured at start as the payload length |
| fifo_valid | input | 1 | FIFO has a byte at its head |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_ready | output | 1 | Pop strobe; a transfer occurs when it and `fifo_valid` are both high |
| bit_tick | input | 1 | Baud strobe, one cycle per bit |
| tx_data | output | 1 | Serial data out |
| busy | output | 1 | Packet in progress |
| pkt_sent | output | 1 | One-cycle packet-complete event |
| underflow | output | 1 | One-cycle abort event on FIFO starvation |
| done_state | output | ST_W (4) | Completion code of the last packet that completed |

## Verification
Each new bit appears on `tx_data` at the same edge that samples `bit_tick` high, so the bench records a bit at the falling edge after each tick that found the block busy. A pop happens in the tick cycle itself, because `fifo_ready` is combinational from the tick. `pkt_sent`, `underflow` and `done_state` change one full tick after the last bit, or at the starving tick in the case of an underflow. The bench therefore counts every tick spent on a packet and expects N+1 of them for N bits. The sweep covers framing on and off, every sync length, header on and off, and several payload sizes. It compares each whole bit stream against one rebuilt arithmetically from the requirement text, with its own CRC.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 16;
  localparam int CRC_BYTES = CRC_W / BYTE_W;
  localparam int NFLD      = 5;

  // Field order of a framed packet; the sequencer walks them upward.
  typedef enum logic [2:0] {
    F_PRE  = 3'd0,
    F_SYNC = 3'd1,
    F_HDR  = 3'd2,
    F_PAY  = 3'd3,
    F_CRC  = 3'd4,
    F_END  = 3'd5
  } field_e;

  localparam logic [BYTE_W-1:0] PRE_PATTERN = 8'hAA;
endpackage

// File: rtl/pkt_tx_crc.sv
module pkt_tx_crc #(
  parameter int              CRC_W = 16,
  parameter int              DW    = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic [DW-1:0]    din,
  output logic [CRC_W-1:0] crc
);
  // One byte per enable: a chain of DW single-bit LFSR steps.
  logic [CRC_W-1:0] stage [DW+1];
  assign stage[0] = crc;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb         = stage[i][CRC_W-1] ^ din[DW-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= INIT;
    else if (init)  crc <= INIT;
    else if (en)    crc <= stage[DW];
  end
endmodule

// File: rtl/pkt_tx_shift.sv
module pkt_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          tx
);
  logic [DW-2:0] rest;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tx   <= 1'b0;
      rest <= '0;
    end else if (load) begin
      {tx, rest} <= din;
    end else if (shift) begin
      {tx, rest} <= {rest, 1'b0};
    end
  end
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
  import pkt_tx_pkg::*;
#(
  parameter  int LVL_W      = 8,
  parameter  int PRE_W      = 8,
  parameter  int SYNC_BYTES = 4,
  parameter  int HDR_BYTES  = 2,
  parameter  int ST_W       = 4,
  localparam int SL_W   = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
  localparam int HI_W   = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1,
  localparam int SYNC_W = BYTE_W * SYNC_BYTES,
  localparam int HDR_W  = BYTE_W * HDR_BYTES,
  localparam int CNT_W  = ((LVL_W > PRE_W) ? LVL_W : PRE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ST_W-1:0]   start_next,
  input  logic              cfg_frame_en,
  input  logic [PRE_W-1:0]  cfg_pre_bytes,
  input  logic [SL_W-1:0]   cfg_sync_bytes,
  input  logic [SYNC_W-1:0] cfg_sync_word,
  input  logic              cfg_hdr_en,
  input  logic [HDR_W-1:0]  cfg_hdr_word,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              bit_tick,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              fifo_ready,
  output logic              sh_load,
  output logic              sh_shift,
  output logic              sh_clr,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              crc_init,
  output logic              crc_en,
  output logic              busy,
  output logic              pkt_sent,
  output logic              underflow,
  output logic [ST_W-1:0]   done_state
);
  // Snapshot of everything taken at start
  logic              s_ph, s_hdr;
  logic [PRE_W-1:0]  s_pre;
  logic [SL_W-1:0]   s_sl;
  logic [SYNC_W-1:0] s_sync;
  logic [HDR_W-1:0]  s_hw;
  logic [LVL_W-1:0]  s_lvl;
  logic [ST_W-1:0]   s_ret;

  field_e            field, first_fld, next_fld;
  logic [CNT_W-1:0]  byte_idx;
  logic [2:0]        bit_idx;

  // Effective configuration: live inputs while idle (for the start
  // decision), the snapshot while a packet is running.
  logic              eff_ph, eff_hdr;
  logic [PRE_W-1:0]  eff_pre;
  logic [SL_W-1:0]   eff_sl;
  logic [LVL_W-1:0]  eff_lvl;

  assign eff_ph  = busy ? s_ph  : cfg_frame_en;
  assign eff_hdr = busy ? s_hdr : cfg_hdr_en;
  assign eff_pre = busy ? s_pre : cfg_pre_bytes;
  assign eff_sl  = busy ? s_sl  : cfg_sync_bytes;
  assign eff_lvl = busy ? s_lvl : fifo_level;

  logic [CNT_W-1:0] len_arr [NFLD];
  logic [CNT_W-1:0] cur_len;

  always_comb begin
    len_arr[0] = eff_ph ? ((eff_pre == '0) ? CNT_W'(1) : CNT_W'(eff_pre)) : '0;
    len_arr[1] = eff_ph ? (CNT_W'(eff_sl) + CNT_W'(1)) : '0;
    len_arr[2] = (eff_ph && eff_hdr) ? CNT_W'(HDR_BYTES) : '0;
    len_arr[3] = CNT_W'(eff_lvl);
    len_arr[4] = eff_ph ? CNT_W'(CRC_BYTES) : '0;
  end

  // First non-empty field overall, and first non-empty field after the
  // current one; F_END when none is left.
  always_comb begin
    first_fld = F_END;
    next_fld  = F_END;
    for (int k = NFLD - 1; k >= 0; k--) begin
      if (len_arr[k] != '0) begin
        first_fld = field_e'(k[2:0]);
        if (k > int'(field)) next_fld = field_e'(k[2:0]);
      end
    end
  end

  always_comb begin
    case (field)
      F_PRE:   cur_len = len_arr[0];
      F_SYNC:  cur_len = len_arr[1];
      F_HDR:   cur_len = len_arr[2];
      F_PAY:   cur_len = len_arr[3];
      F_CRC:   cur_len = len_arr[4];
      default: cur_len = '0;
    endcase
  end

  // Byte source for the current field position
  logic [SYNC_W-1:0] sync_sh;
  logic [HDR_W-1:0]  hdr_sh;
  assign sync_sh = s_sync << (BYTE_W * int'(byte_idx[SL_W-1:0]));
  assign hdr_sh  = s_hw   << (BYTE_W * int'(byte_idx[HI_W-1:0]));

  always_comb begin
    case (field)
      F_PRE:   cur_byte = PRE_PATTERN;
      F_SYNC:  cur_byte = sync_sh[SYNC_W-1 -: BYTE_W];
      F_HDR:   cur_byte = hdr_sh[HDR_W-1 -: BYTE_W];
      F_PAY:   cur_byte = fifo_data;
      F_CRC:   cur_byte = byte_idx[0] ? crc_val[BYTE_W-1:0] : crc_val[CRC_W-1 -: BYTE_W];
      default: cur_byte = '0;
    endcase
  end

  logic act, byte_start, starve, at_end;
  assign act        = busy && bit_tick;
  assign at_end     = (field == F_END);
  assign byte_start = (bit_idx == 3'd0);
  assign starve     = (field == F_PAY) && byte_start && !fifo_valid;

  assign fifo_ready = act && (field == F_PAY) && byte_start;
  assign sh_load    = act && !at_end && byte_start && !starve;
  assign sh_shift   = act && !at_end && !byte_start;
  assign sh_clr     = act && (at_end || starve);
  assign crc_init   = !busy && start;
  assign crc_en     = sh_load && ((field == F_HDR) || (field == F_PAY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pkt_sent   <= 1'b0;
      underflow  <= 1'b0;
      done_state <= '0;
      field      <= F_END;
      byte_idx   <= '0;
      bit_idx    <= '0;
      s_ph       <= 1'b0;
      s_hdr      <= 1'b0;
      s_pre      <= '0;
      s_sl       <= '0;
      s_sync     <= '0;
      s_hw       <= '0;
      s_lvl      <= '0;
      s_ret      <= '0;
    end else begin
      pkt_sent  <= 1'b0;
      underflow <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          s_ph     <= cfg_frame_en;
          s_hdr    <= cfg_hdr_en;
          s_pre    <= cfg_pre_bytes;
          s_sl     <= cfg_sync_bytes;
          s_sync   <= cfg_sync_word;
          s_hw     <= cfg_hdr_word;
          s_lvl    <= fifo_level;
          s_ret    <= start_next;
          field    <= first_fld;
          byte_idx <= '0;
          bit_idx  <= '0;
        end
      end else if (bit_tick) begin
        if (at_end) begin
          busy       <= 1'b0;
          pkt_sent   <= 1'b1;
          done_state <= s_ret;
        end else if (starve) begin
          busy      <= 1'b0;
          underflow <= 1'b1;
        end else if (bit_idx == 3'd7) begin
          bit_idx <= '0;
          if (byte_idx == cur_len - CNT_W'(1)) begin
            field    <= next_fld;
            byte_idx <= '0;
          end else begin
            byte_idx <= byte_idx + CNT_W'(1);
          end
        end else begin
          bit_idx <= bit_idx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import pkt_tx_pkg::*;
#(
  parameter  int              LVL_W      = 8,
  parameter  int              PRE_W      = 8,
  parameter  int              SYNC_BYTES = 4,
  parameter  int              HDR_BYTES  = 2,
  parameter  int              ST_W       = 4,
  parameter  logic [15:0]     CRC_POLY   = 16'h1021,
  parameter  logic [15:0]     CRC_INIT   = 16'hFFFF,
  localparam int SL_W   = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
  localparam int SYNC_W = 8 * SYNC_BYTES,
  localparam int HDR_W  = 8 * HDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ST_W-1:0]   start_next,
  input  logic              cfg_frame_en,
  input  logic [PRE_W-1:0]  cfg_pre_bytes,
  input  logic [SL_W-1:0]   cfg_sync_bytes,
  input  logic [SYNC_W-1:0] cfg_sync_word,
  input  logic              cfg_hdr_en,
  input  logic [HDR_W-1:0]  cfg_hdr_word,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_valid,
  input  logic [7:0]        fifo_data,
  output logic              fifo_ready,
  input  logic              bit_tick,
  output logic              tx_data,
  output logic              busy,
  output logic              pkt_sent,
  output logic              underflow,
  output logic [ST_W-1:0]   done_state
);
  logic              sh_load, sh_shift, sh_clr;
  logic              crc_init, crc_en;
  logic [BYTE_W-1:0] cur_byte;
  logic [CRC_W-1:0]  crc_val;

  pkt_tx_seq #(
    .LVL_W(LVL_W), .PRE_W(PRE_W), .SYNC_BYTES(SYNC_BYTES),
    .HDR_BYTES(HDR_BYTES), .ST_W(ST_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_next(start_next),
    .cfg_frame_en(cfg_frame_en), .cfg_pre_bytes(cfg_pre_bytes),
    .cfg_sync_bytes(cfg_sync_bytes), .cfg_sync_word(cfg_sync_word),
    .cfg_hdr_en(cfg_hdr_en), .cfg_hdr_word(cfg_hdr_word),
    .fifo_level(fifo_level), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .bit_tick(bit_tick), .crc_val(crc_val), .fifo_ready(fifo_ready),
    .sh_load(sh_load), .sh_shift(sh_shift), .sh_clr(sh_clr),
    .cur_byte(cur_byte), .crc_init(crc_init), .crc_en(crc_en),
    .busy(busy), .pkt_sent(pkt_sent), .underflow(underflow),
    .done_state(done_state)
  );

  pkt_tx_shift #(.DW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load),
    .shift(sh_shift), .din(cur_byte), .tx(tx_data)
  );

  pkt_tx_crc #(.CRC_W(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(cur_byte), .crc(crc_val)
  );
endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk #(
  parameter int ST_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bit_tick,
  input logic            tx_data,
  input logic            busy,
  input logic            fifo_ready,
  input logic            pkt_sent,
  input logic            underflow,
  input logic [ST_W-1:0] done_state
);
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_data);

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_data));

  assert_pop_in_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (busy && bit_tick));

  assert_sent_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |-> (!busy && !underflow));

  assert_state_moves_only_on_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_sent |-> $stable(done_state));

  assert_end_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pkt_sent || underflow));

  assert_underflow_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);
endmodule

bind pkt_tx_framer pkt_tx_framer_chk #(.ST_W(ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_data(tx_data),
  .busy(busy), .fifo_ready(fifo_ready), .pkt_sent(pkt_sent),
  .underflow(underflow), .done_state(done_state)
);

// File: tb/sim_pkt_tx_framer.sv
module sim_pkt_tx_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  start_next = '0;
  logic        cfg_frame_en = 1'b0;
  logic [7:0]  cfg_pre_bytes = '0;
  logic [1:0]  cfg_sync_bytes = '0;
  logic [31:0] cfg_sync_word = '0;
  logic        cfg_hdr_en = 1'b0;
  logic [15:0] cfg_hdr_word = '0;
  logic [7:0]  fifo_level = '0;
  logic        fifo_valid;
  logic [7:0]  fifo_data;
  logic        fifo_ready;
  logic        bit_tick = 1'b0;
  logic        tx_data, busy, pkt_sent, underflow;
  logic [3:0]  done_state;

  always #10 clk = ~clk;

  pkt_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_next(start_next),
    .cfg_frame_en(cfg_frame_en), .cfg_pre_bytes(cfg_pre_bytes),
    .cfg_sync_bytes(cfg_sync_bytes), .cfg_sync_word(cfg_sync_word),
    .cfg_hdr_en(cfg_hdr_en), .cfg_hdr_word(cfg_hdr_word),
    .fifo_level(fifo_level), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .bit_tick(bit_tick), .tx_data(tx_data),
    .busy(busy), .pkt_sent(pkt_sent), .underflow(underflow),
    .done_state(done_state)
  );

  // FIFO model
  logic [7:0] q [0:255];
  int q_cnt = 0;
  int q_rd  = 0;
  logic q_clr = 1'b0;
  assign fifo_valid = (q_rd < q_cnt);
  assign fifo_data  = q[q_rd[7:0]];
  always @(posedge clk) begin
    if (q_clr) q_rd <= 0;
    else if (fifo_ready && fifo_valid) q_rd <= q_rd + 1;
  end

  // Baud tick every third cycle, driven away from the active edge
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 3;
    bit_tick = (tcnt == 0);
  end

  // A tick that found the block busy at the edge
  logic tick_q = 1'b0;
  always @(posedge clk) tick_q <= bit_tick && busy;

  int ncmp = 0, nbad = 0;
  bit wd = 1'b0;
  bit capb [0:4095];
  bit expb [0:4095];
  int ncap, nexp;

  task automatic chk(input string req, input string what, input int act, input int expv);
    ncmp++;
    if (act != expv) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      expb[nexp] = b[i];
      nexp++;
    end
  endtask

  // seed < 0 selects the ASCII "123456789..." payload
  task automatic run_pkt(input string req, input bit ph, input int pre, input int sl,
                         input bit he, input int nlen, input int avail,
                         input logic [3:0] arg, input bit meddle, input int seed);
    logic [15:0] crc;
    logic [31:0] sw;
    logic [15:0] hw;
    logic [3:0]  prev_done;
    int nsent, nunder, nticks, bad_at, cyc;
    bit complete;
    complete = (avail >= nlen);
    sw = 32'hD391_7A2C ^ (seed * 32'h0101_0101);
    hw = 16'hC5E1 ^ 16'(seed * 7);
    for (int i = 0; i < avail; i++)
      q[i] = (seed < 0) ? 8'(8'h31 + i) : 8'(8'h5A ^ (i * 29) ^ seed);
    q_cnt = avail;
    q_clr = 1'b1;
    @(negedge clk);
    q_clr = 1'b0;
    prev_done = done_state;

    // Expected stream, built from the field rules
    nexp = 0;
    crc  = 16'hFFFF;
    if (ph) begin
      for (int i = 0; i < ((pre == 0) ? 1 : pre); i++) push_byte(8'hAA);
      for (int i = 0; i <= sl; i++) push_byte(sw[31 - 8*i -: 8]);
      if (he) begin
        push_byte(hw[15:8]); crc = crc_ref(crc, hw[15:8]);
        push_byte(hw[7:0]);  crc = crc_ref(crc, hw[7:0]);
      end
    end
    for (int i = 0; i < ((avail < nlen) ? avail : nlen); i++) begin
      push_byte(q[i]);
      crc = crc_ref(crc, q[i]);
    end
    if (ph && complete) begin
      push_byte(crc[15:8]);
      push_byte(crc[7:0]);
    end

    cfg_frame_en   = ph;
    cfg_pre_bytes  = 8'(pre);
    cfg_sync_bytes = 2'(sl);
    cfg_sync_word  = sw;
    cfg_hdr_en     = he;
    cfg_hdr_word   = hw;
    fifo_level     = 8'(nlen);
    start_next     = arg;
    start          = 1'b1;
    @(negedge clk);
    start = 1'b0;

    ncap = 0; nsent = 0; nunder = 0; nticks = 0; cyc = 0;
    while ((busy || cyc == 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (tick_q) begin
        nticks++;
        if (busy) begin capb[ncap] = tx_data; ncap++; end
      end
      if (pkt_sent) nsent++;
      if (underflow) nunder++;
      if (meddle && cyc == 6) begin
        cfg_frame_en = ~ph; cfg_pre_bytes = 8'd9; cfg_sync_bytes = ~2'(sl);
        cfg_sync_word = ~sw; cfg_hdr_en = ~he; cfg_hdr_word = ~hw;
        fifo_level = 8'd77; start_next = ~arg; start = 1'b1;
      end
      if (meddle && cyc == 7) start = 1'b0;
    end
    repeat (2) begin
      @(negedge clk);
      if (pkt_sent) nsent++;
      if (underflow) nunder++;
    end

    chk(req, "bit count", ncap, nexp);
    bad_at = -1;
    for (int i = 0; i < ncap && i < nexp; i++)
      if (bad_at < 0 && capb[i] != expb[i]) bad_at = i;
    if (bad_at >= 0) chk(req, $sformatf("bit %0d", bad_at), int'(capb[bad_at]), int'(expb[bad_at]));
    else chk(req, "stream content", 0, 0);
    chk("R10", "idle line", int'(tx_data), 0);
    if (complete) begin
      chk("R8", "pkt_sent pulses", nsent, 1);
      chk("R8", "done_state", int'(done_state), int'(arg));
      chk("R3", "ticks used", nticks, nexp + 1);
      chk("R7", "fifo pops", q_rd, nlen);
      chk("R9", "no underflow", nunder, 0);
    end else begin
      chk("R9", "underflow pulses", nunder, 1);
      chk("R9", "no pkt_sent", nsent, 0);
      chk("R9", "done_state kept", int'(done_state), int'(prev_done));
    end
  endtask

  task automatic run_all();
    int idx = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "tx in reset", int'(tx_data), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx after reset", int'(tx_data), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "ready after reset", int'(fifo_ready), 0);
    chk("R1", "events after reset", int'(pkt_sent) + int'(underflow), 0);
    chk("R1", "done_state after reset", int'(done_state), 0);

    // R4 / R5 sweep of framed packets
    for (int pre = 1; pre <= 2; pre++)
      for (int sl = 0; sl < 4; sl++)
        for (int he = 0; he < 2; he++)
          for (int ln = 0; ln < 3; ln++) begin
            run_pkt("R4", 1'b1, pre, sl, he[0], (ln == 2) ? 3 : ln, (ln == 2) ? 3 : ln,
                    4'(idx), 1'b0, idx);
            idx++;
          end

    // R6: unframed, including an empty packet (R8 edge)
    run_pkt("R6", 1'b0, 3, 2, 1'b1, 0, 0, 4'h3, 1'b0, 11);
    run_pkt("R6", 1'b0, 3, 2, 1'b1, 1, 1, 4'h5, 1'b0, 12);
    run_pkt("R6", 1'b0, 0, 0, 1'b0, 6, 6, 4'h9, 1'b0, 13);

    // R4: preamble length 0 behaves as 1, long preamble
    run_pkt("R4", 1'b1, 0, 1, 1'b0, 2, 2, 4'hA, 1'b0, 21);
    run_pkt("R4", 1'b1, 255, 3, 1'b1, 2, 2, 4'hB, 1'b0, 22);

    // R5: known CRC vector over "123456789"
    run_pkt("R5", 1'b1, 1, 0, 1'b0, 9, 9, 4'hC, 1'b0, -1);
    begin
      int crc_seen = 0;
      for (int i = 0; i < 16; i++) crc_seen = (crc_seen << 1) | int'(capb[ncap - 16 + i]);
      chk("R5", "CRC of 123456789", crc_seen, 16'h29B1);
    end

    // R2: restart and configuration changes while busy are ignored
    run_pkt("R2", 1'b1, 2, 3, 1'b1, 4, 4, 4'h6, 1'b1, 31);
    run_pkt("R2", 1'b0, 1, 0, 1'b0, 5, 5, 4'h7, 1'b1, 32);

    // R9: FIFO starves during payload, framed and unframed
    run_pkt("R9", 1'b1, 1, 1, 1'b1, 4, 2, 4'hE, 1'b0, 41);
    run_pkt("R9", 1'b0, 1, 0, 1'b0, 3, 0, 4'hF, 1'b0, 42);
    run_pkt("R8", 1'b1, 1, 0, 1'b0, 1, 1, 4'h2, 1'b0, 43);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (180000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      ncmp++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule